// File: doc/BRIEF.md
# Accelerator Launch and Argument Register Slave

This block is the host-facing register file of a compute engine. A host reaches it over AXI4-Lite, programs an element count and the 64-bit base addresses of two memory buffers, and then sets a start bit to launch the engine. The argument values go straight out to the engine as ports. When the bit flips from 0 to 1, the engine gets a single-cycle launch pulse.

While the engine runs, the start bit stays set and the idle bit stays clear. The engine reports that it has finished with a one-cycle completion pulse. In that same cycle the block clears start, sets done and raises idle. The host finds out that the run ended by polling the control word. That read returns done as 1 and clears it, so each completion is seen exactly once.

Top module: `acc_ctrl_regs`

## Requirements
- R1: After reset the control word at offset 0x00 reads 0x4 (bit 0 start = 0, bit 1 done = 0, bit 2 idle = 1). Every argument register reads 0. The argument outputs are 0 and launch_o is low.
- R2: Five 32-bit argument words can be written and read back, and each one drives its output directly:
  - offset 0x10 is elem_count_o;
  - offsets 0x18 and 0x1C are the low and high halves of base_a_o;
  - offsets 0x24 and 0x28 are the low and high halves of base_b_o.
- R3: A write changes only the bytes whose write-strobe bit is set. Strobe bit n guards data bits 8n+7..8n.
- R4: A write to 0x00 with strobe bit 0 set and data bit 0 = 1, made while idle, does three things on the clock edge that issues the write response. It sets start and clears idle. launch_o is then high for exactly that one cycle, which is the first cycle in which the write response is valid.
- R5: While a run is in progress, start stays 1 until the completion pulse. Writing 0 or 1 to start during the run has no effect and produces no further launch pulse.
- R6: A completion pulse on engine_done_i during a run clears start and sets both done and idle on the same edge. A completion pulse while idle is ignored.
- R7: A read of 0x00 returns the current done value and clears done. If a completion arrives on the same edge as that read, done ends up set.
- R8: Writes to the done and idle bits have no effect.
- R9: A read of any other offset, including any address with a nonzero value in bits 1..0, returns 0 with an OKAY response. A write there changes nothing and gets an OKAY response.
- R10: The write address and write data are accepted independently and in either order, and one response follows once both are held. A write response or read response stays valid, with its data stable, until the host accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| launch_o | output | 1 | One-cycle launch pulse to the engine |
| engine_done_i | input | 1 | One-cycle completion pulse from the engine |
| elem_count_o | output | 32 | Element-count argument |
| base_a_o | output | 64 | Base address of buffer A |
| base_b_o | output | 64 | Base address of buffer B |

## Verification
Once both halves of a write are held, the write takes effect on the next edge. Register contents, the start and idle changes and launch_o all appear on that same edge, together with the write response. A read response arrives one edge after the address is accepted and shows the register values from the cycle before that edge. The completion pulse affects the control word on the edge that samples it. The bench drives every input on falling edges and samples on falling edges. It checks launch_o in the exact cycle the write response first appears. It also forces a read of 0x00 and a completion onto the same edge to confirm which of the two wins.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned STRB_W   = WORD_W / 8;
  localparam int unsigned NUM_ARGS = 5;

  // Word indexes (byte offset / 4) of the mapped registers
  localparam int unsigned IDX_CTRL = 0;

  typedef struct packed {
    logic idle;
    logic done;
    logic start;
  } ctrl_bits_t;

  // Word index of argument slot k: count, A low, A high, B low, B high
  function automatic int unsigned arg_index(input int unsigned k);
    case (k)
      0:       return 4;
      1:       return 6;
      2:       return 7;
      3:       return 9;
      default: return 10;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] merge_bytes(input logic [WORD_W-1:0] old_v,
                                                    input logic [WORD_W-1:0] new_v,
                                                    input logic [STRB_W-1:0] strb);
    logic [WORD_W-1:0] r;
    r = old_v;
    for (int b = 0; b < int'(STRB_W); b++) begin
      if (strb[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/acr_wr_chan.sv
module acr_wr_chan
  import acr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [WORD_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  output logic              bvalid,
  input  logic              bready,
  output logic [1:0]        bresp,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb
);
  logic              aw_held, w_held, bvalid_q;
  logic [ADDR_W-1:0] aw_q;
  logic [WORD_W-1:0] d_q;
  logic [STRB_W-1:0] s_q;

  assign awready = ~aw_held;
  assign wready  = ~w_held;
  assign bvalid  = bvalid_q;
  assign bresp   = 2'b00;
  assign wr_en   = aw_held & w_held & ~bvalid_q;
  assign wr_addr = aw_q;
  assign wr_data = d_q;
  assign wr_strb = s_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_held  <= 1'b0;
      w_held   <= 1'b0;
      bvalid_q <= 1'b0;
      aw_q     <= '0;
      d_q      <= '0;
      s_q      <= '0;
    end else begin
      if (awvalid && !aw_held) begin
        aw_held <= 1'b1;
        aw_q    <= awaddr;
      end
      if (wvalid && !w_held) begin
        w_held <= 1'b1;
        d_q    <= wdata;
        s_q    <= wstrb;
      end
      if (wr_en) begin
        aw_held  <= 1'b0;
        w_held   <= 1'b0;
        bvalid_q <= 1'b1;
      end else if (bvalid_q && bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bvalid && !bready) |=> bvalid); // R10
  AST_AW_KEPT: assert property (@(posedge clk) disable iff (rst)
    (aw_held && !wr_en) |=> (aw_held && $stable(aw_q))); // R10
endmodule

// File: rtl/acr_rd_chan.sv
module acr_rd_chan
  import acr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  output logic              rvalid,
  input  logic              rready,
  output logic [WORD_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_fire,
  input  logic [WORD_W-1:0] rd_word
);
  logic              rvalid_q;
  logic [WORD_W-1:0] rdata_q;

  assign arready = ~rvalid_q;
  assign rd_fire = arvalid & ~rvalid_q;
  assign rd_addr = araddr;
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;
  assign rresp   = 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (rd_fire) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_word;
    end else if (rvalid_q && rready) begin
      rvalid_q <= 1'b0;
    end
  end

  AST_R_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rvalid && !rready) |=> (rvalid && $stable(rdata))); // R10
endmodule

// File: rtl/acr_arg_reg.sv
module acr_arg_reg
  import acr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= merge_bytes(q, wdata, wstrb);
  end

  AST_ARG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q)); // R2
endmodule

// File: rtl/acr_ctrl_core.sv
module acr_ctrl_core
  import acr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ctrl,
  input  logic       wr_start_bit,
  input  logic       rd_clear,
  input  logic       engine_done,
  output ctrl_bits_t state,
  output logic       launch
);
  ctrl_bits_t st_q;
  logic       launch_q;

  assign state  = st_q;
  assign launch = launch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= '{idle: 1'b1, done: 1'b0, start: 1'b0};
      launch_q <= 1'b0;
    end else begin
      launch_q <= 1'b0;
      if (rd_clear) st_q.done <= 1'b0;
      if (st_q.idle) begin
        if (wr_ctrl && wr_start_bit) begin
          st_q.start <= 1'b1;
          st_q.idle  <= 1'b0;
          launch_q   <= 1'b1;
        end
      end else if (engine_done) begin
        st_q.start <= 1'b0;
        st_q.idle  <= 1'b1;
        st_q.done  <= 1'b1;
      end
    end
  end

  AST_LAUNCH_ONE: assert property (@(posedge clk) disable iff (rst)
    launch |=> !launch); // R4
  AST_LAUNCH_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    launch |-> ($past(st_q.idle) && st_q.start && !st_q.idle)); // R4
  AST_START_HELD: assert property (@(posedge clk) disable iff (rst)
    (st_q.start && !engine_done) |=> st_q.start); // R5
  AST_IDLE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q.idle) |-> (st_q.done && !st_q.start)); // R6
  AST_DONE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (st_q.done && !rd_clear) |=> st_q.done); // R8
endmodule

// File: rtl/acc_ctrl_regs.sv
module acc_ctrl_regs
  import acr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              launch_o,
  input  logic              engine_done_i,
  output logic [31:0]       elem_count_o,
  output logic [63:0]       base_a_o,
  output logic [63:0]       base_b_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic              wr_en, rd_fire;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [WORD_W-1:0] wr_data, rd_word;
  logic [STRB_W-1:0] wr_strb;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              wr_align, rd_align, rd_mapped;
  logic [WORD_W-1:0] arg_q [NUM_ARGS];
  ctrl_bits_t        cstate;

  assign wr_idx   = wr_addr[ADDR_W-1:2];
  assign rd_idx   = rd_addr[ADDR_W-1:2];
  assign wr_align = (wr_addr[1:0] == 2'b00);
  assign rd_align = (rd_addr[1:0] == 2'b00);

  acr_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst(rst),
    .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
    .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata), .wstrb(s_wstrb),
    .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb)
  );

  acr_rd_chan #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst),
    .arvalid(s_arvalid), .arready(s_arready), .araddr(s_araddr),
    .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
    .rd_addr(rd_addr), .rd_fire(rd_fire), .rd_word(rd_word)
  );

  for (genvar k = 0; k < int'(NUM_ARGS); k++) begin : g_arg
    logic we_k;
    assign we_k = wr_en && wr_align && (32'(wr_idx) == arg_index(k));
    acr_arg_reg u_arg (
      .clk(clk), .rst(rst), .we(we_k),
      .wdata(wr_data), .wstrb(wr_strb), .q(arg_q[k])
    );
  end

  acr_ctrl_core u_core (
    .clk(clk), .rst(rst),
    .wr_ctrl(wr_en && wr_align && (32'(wr_idx) == IDX_CTRL) && wr_strb[0]),
    .wr_start_bit(wr_data[0]),
    .rd_clear(rd_fire && rd_align && (32'(rd_idx) == IDX_CTRL)),
    .engine_done(engine_done_i),
    .state(cstate),
    .launch(launch_o)
  );

  always_comb begin
    rd_word   = '0;
    rd_mapped = 1'b0;
    if (rd_align) begin
      if (32'(rd_idx) == IDX_CTRL) begin
        rd_word   = {{(WORD_W-3){1'b0}}, cstate};
        rd_mapped = 1'b1;
      end
      for (int unsigned k = 0; k < NUM_ARGS; k++) begin
        if (32'(rd_idx) == arg_index(k)) begin
          rd_word   = arg_q[k];
          rd_mapped = 1'b1;
        end
      end
    end
  end

  assign elem_count_o = arg_q[0];
  assign base_a_o     = {arg_q[2], arg_q[1]};
  assign base_b_o     = {arg_q[4], arg_q[3]};

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && !rd_mapped) |=> (s_rvalid && s_rdata == '0)); // R9
  AST_OKAY_RESP: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid || s_rvalid) |-> (s_bresp == 2'b00 && s_rresp == 2'b00)); // R9
endmodule

// File: tb/sim_acc_ctrl_regs.sv
module sim_acc_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic [7:0]  s_awaddr = '0, s_araddr = '0;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        engine_done_i = 0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid, launch_o;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata, elem_count_o;
  logic [63:0] base_a_o, base_b_o;

  int n_chk = 0, n_fail = 0, launches = 0;
  logic [7:0]  addr_tbl [5] = '{8'h10, 8'h18, 8'h1C, 8'h24, 8'h28};
  logic [31:0] exp_arg [5] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0};

  always #10 clk = ~clk;

  acc_ctrl_regs #(.ADDR_W(8)) u0 (
    .clk(clk), .rst(rst),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .launch_o(launch_o), .engine_done_i(engine_done_i),
    .elem_count_o(elem_count_o), .base_a_o(base_a_o), .base_b_o(base_b_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R4: launch must show up in the first cycle the write response is valid
  always @(negedge clk) begin
    if (!rst && launch_o) begin
      launches++;
      chk("R4 launch aligned with write response", 64'(s_bvalid), 64'd1);
    end
  end

  task automatic axi_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                        input int aw_dly, input int w_dly);
    logic aw_ok, w_ok, ag, wg;
    int c;
    aw_ok = 0; w_ok = 0; c = 0;
    s_awaddr = a; s_wdata = d; s_wstrb = s;
    while (!(aw_ok && w_ok)) begin
      s_awvalid = !aw_ok && (c >= aw_dly);
      s_wvalid  = !w_ok && (c >= w_dly);
      ag = s_awvalid && s_awready;
      wg = s_wvalid && s_wready;
      @(posedge clk); @(negedge clk);
      if (ag) aw_ok = 1;
      if (wg) w_ok = 1;
      c++;
    end
    s_awvalid = 0; s_wvalid = 0;
    s_bready = 1;
    while (!s_bvalid) @(negedge clk);
    chk("R9 write response OKAY", 64'(s_bresp), 64'd0);
    @(posedge clk); @(negedge clk);
    s_bready = 0;
  endtask

  task automatic axi_rd(input logic [7:0] a, output logic [31:0] d);
    logic g;
    s_araddr = a; s_arvalid = 1;
    g = 0;
    while (!g) begin
      g = s_arready;
      @(posedge clk); @(negedge clk);
    end
    s_arvalid = 0;
    s_rready = 1;
    while (!s_rvalid) @(negedge clk);
    d = s_rdata;
    chk("R9 read response OKAY", 64'(s_rresp), 64'd0);
    @(posedge clk); @(negedge clk);
    s_rready = 0;
  endtask

  task automatic pulse_done();
    engine_done_i = 1;
    @(posedge clk); @(negedge clk);
    engine_done_i = 0;
  endtask

  function automatic logic [31:0] bmerge(input logic [31:0] o, input logic [31:0] n,
                                         input logic [3:0] s);
    logic [31:0] r;
    r = o;
    for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd, d, e;
    int lc;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 launch low", 64'(launch_o), 64'd0);
    chk("R1 count out", 64'(elem_count_o), 64'd0);
    chk("R1 base A out", base_a_o, 64'd0);
    chk("R1 base B out", base_b_o, 64'd0);
    axi_rd(8'h00, rd); chk("R1 control word", 64'(rd), 64'h4);
    for (int k = 0; k < 5; k++) begin
      axi_rd(addr_tbl[k], rd); chk("R1 argument reset", 64'(rd), 64'd0);
    end

    // R2 / R3 sweep of every strobe pattern on every argument word
    for (int k = 0; k < 5; k++) begin
      for (int s = 0; s < 16; s++) begin
        d = 32'h9E3779B9 * 32'(k * 16 + s + 1);
        exp_arg[k] = bmerge(exp_arg[k], d, 4'(s));
        axi_wr(addr_tbl[k], d, 4'(s), 0, 0);
        axi_rd(addr_tbl[k], rd);
        chk("R3 strobed write readback", 64'(rd), 64'(exp_arg[k]));
      end
    end
    chk("R2 count exported", 64'(elem_count_o), 64'(exp_arg[0]));
    chk("R2 base A exported", base_a_o, {exp_arg[2], exp_arg[1]});
    chk("R2 base B exported", base_b_o, {exp_arg[4], exp_arg[3]});

    // R10 address and data in either order
    exp_arg[0] = 32'hCAFE0123;
    axi_wr(8'h10, exp_arg[0], 4'hF, 0, 3);
    axi_rd(8'h10, rd); chk("R10 address before data", 64'(rd), 64'(exp_arg[0]));
    exp_arg[3] = 32'h0BAD0F00;
    axi_wr(8'h24, exp_arg[3], 4'hF, 3, 0);
    axi_rd(8'h24, rd); chk("R10 data before address", 64'(rd), 64'(exp_arg[3]));
    chk("R2 base B low after write", base_b_o, {exp_arg[4], exp_arg[3]});

    // R10 read response held while not accepted
    s_araddr = 8'h10; s_arvalid = 1;
    @(posedge clk); @(negedge clk);
    s_arvalid = 0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R10 rvalid held", 64'(s_rvalid), 64'd1);
      chk("R10 rdata stable", 64'(s_rdata), 64'(exp_arg[0]));
    end
    s_rready = 1; @(posedge clk); @(negedge clk); s_rready = 0;
    chk("R10 rvalid drops after accept", 64'(s_rvalid), 64'd0);

    // R9 unmapped writes ignored, then sweep every word address
    axi_wr(8'h30, 32'hFFFFFFFF, 4'hF, 0, 0);
    axi_wr(8'h11, 32'hFFFFFFFF, 4'hF, 0, 0);
    axi_wr(8'h14, 32'hFFFFFFFF, 4'hF, 0, 0);
    for (int w = 0; w < 64; w++) begin
      e = 32'd0;
      if (w == 0) e = 32'h4;
      for (int k = 0; k < 5; k++) if (addr_tbl[k] == 8'(w * 4)) e = exp_arg[k];
      axi_rd(8'(w * 4), rd);
      chk("R9 address sweep", 64'(rd), 64'(e));
    end
    axi_rd(8'h12, rd); chk("R9 misaligned read zero", 64'(rd), 64'd0);

    // R8 / R3: no launch without strobe 0; done and idle not writable
    lc = launches;
    axi_wr(8'h00, 32'h1, 4'hE, 0, 0);
    axi_rd(8'h00, rd); chk("R3 start needs strobe 0", 64'(rd), 64'h4);
    axi_wr(8'h00, 32'h2, 4'hF, 0, 0);
    axi_rd(8'h00, rd); chk("R8 done not writable", 64'(rd), 64'h4);
    chk("R4 no launch yet", 64'(launches), 64'(lc));

    // R4 launch
    axi_wr(8'h00, 32'h1, 4'h1, 0, 0);
    chk("R4 one launch pulse", 64'(launches), 64'(lc + 1));
    axi_rd(8'h00, rd); chk("R4 busy control word", 64'(rd), 64'h1);

    // R5 start writes during run ignored
    axi_wr(8'h00, 32'h0, 4'hF, 0, 0);
    axi_rd(8'h00, rd); chk("R5 start not clearable", 64'(rd), 64'h1);
    axi_wr(8'h00, 32'h7, 4'hF, 0, 0);
    axi_rd(8'h00, rd); chk("R5 rewrite ignored", 64'(rd), 64'h1);
    chk("R5 no second launch", 64'(launches), 64'(lc + 1));

    // R6 completion
    pulse_done();
    axi_wr(8'h00, 32'h0, 4'hF, 0, 0);
    axi_rd(8'h00, rd); chk("R6 done and idle after completion", 64'(rd), 64'h6);
    axi_rd(8'h00, rd); chk("R7 done cleared by read", 64'(rd), 64'h4);
    pulse_done();
    axi_rd(8'h00, rd); chk("R6 completion while idle ignored", 64'(rd), 64'h4);

    // R7 read of control coinciding with completion
    axi_wr(8'h00, 32'h1, 4'h1, 0, 0);
    chk("R4 second launch", 64'(launches), 64'(lc + 2));
    s_araddr = 8'h00; s_arvalid = 1; engine_done_i = 1;
    @(posedge clk); @(negedge clk);
    s_arvalid = 0; engine_done_i = 0; s_rready = 1;
    while (!s_rvalid) @(negedge clk);
    rd = s_rdata;
    @(posedge clk); @(negedge clk); s_rready = 0;
    chk("R7 read sees pre-completion word", 64'(rd), 64'h1);
    axi_rd(8'h00, rd); chk("R7 completion wins over clear", 64'(rd), 64'h6);
    axi_rd(8'h00, rd); chk("R7 cleared afterwards", 64'(rd), 64'h4);
    chk("R2 arguments kept through run", 64'(elem_count_o), 64'(exp_arg[0]));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule